// File: doc/BRIEF.md
# Fractional Memory Clock Ratio Generator

This block produces a memory clock from the core clock at a divide ratio of 2, 2.5, 3, 3.5, 4, 4.5 or 5. It does not toggle a clock net itself. Every core cycle it emits a pair of half-cycle levels, and a later double-data-rate output stage turns that pair into the pin waveform. Because it counts in core half-periods, the half-integer ratios come out with a falling edge that can land in the middle of a core cycle.

A 3-bit ratio code and a start bit arrive from a register interface. A newly written code is taken only on a 0-to-1 edge of the start bit, and the change is applied at the end of the output period in progress. A one-cycle strobe marks every core cycle that holds a rising edge of the generated clock.

Top module: `sdclk_ratio_gen`

## Requirements
- R1: After reset, and until the first 0-to-1 edge of `start`, `mclk_halves` is 00 and `period_start` is 0. The active ratio code out of reset is 3, which is divide by 3.
- R2: Ratio code c (1 to 7) gives a period of c+3 core half-cycles. Code 1 is divide by 2, code 2 is 2.5, code 3 is 3, code 4 is 3.5, code 5 is 4, code 6 is 4.5 and code 7 is 5. Each period starts with ceil(N/2) high half-cycles followed by floor(N/2) low half-cycles. `mclk_halves[0]` is the first half of the core cycle and `mclk_halves[1]` is the second half.
- R3: `ratio_code` is sampled only in the cycle where `start` is 1 and was 0 in the cycle before. Changing the code while `start` stays high, or while it stays low, has no effect.
- R4: A code of 000 sampled on a start edge is ignored, and the ratio already in effect stays. If that edge is the first one, it still starts the clock, at the ratio held from reset.
- R5: A code accepted while the clock runs takes effect at the next period boundary. The current period finishes at the old ratio, so no shortened high or low phase appears.
- R6: `period_start` is 1 for exactly those core cycles in which a half-cycle at phase 0 of a period is emitted, whether it falls in the first half or the second half.
- R7: Once started, the clock keeps running when `start` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 3 | Requested divide ratio code |
| start | input | 1 | Start bit; only its rising edge counts |
| mclk_halves | output | 2 | Levels of the generated clock for the first half (bit 0) and the second half (bit 1) of this core cycle |
| period_start | output | 1 | Marks a core cycle that holds a rising edge of the generated clock |

## Verification
Every code from 1 to 7 is started from a cleared start bit and run for many periods. This separates the even-length periods from the odd-length ones, whose edges move into the second half of the core cycle. Further patterns cover:
- codes changed while the start level is held, which tells edge sampling apart from level sampling;
- a reserved code on both the first edge and a later edge;
- a switch issued partway through a long period, which shows whether the old period is allowed to finish.

A reference model kept in the bench walks the waveform one half-cycle at a time and predicts both outputs for each cycle.

// File: rtl/sdclk_ratio_gen.sv
module sdclk_ratio_gen #(
  parameter int               CW       = 3,
  parameter logic [CW-1:0]    RST_CODE = 3'd3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ratio_code,
  input  logic          start,
  output logic [1:0]    mclk_halves,
  output logic          period_start
);
  localparam int PW = $clog2((2 ** CW) + 3);

  logic          start_q, run;
  logic [CW-1:0] act_code, pend_code;
  logic [PW-1:0] pos;

  wire           start_edge = start & ~start_q;
  wire [CW-1:0]  pend_nxt   = (start_edge && ratio_code != '0) ? ratio_code : pend_code;
  wire [PW-1:0]  nhalf      = PW'(act_code) + PW'(3);
  wire [PW-1:0]  nhigh      = (nhalf + PW'(1)) >> 1;
  wire [PW-1:0]  pos1       = pos + PW'(1);
  wire [PW-1:0]  pos2       = pos + PW'(2);
  wire           wrap_mid   = (pos1 == nhalf);
  wire           wrap_end   = (pos2 == nhalf);
  wire           half0      = pos < nhigh;
  wire           half1      = wrap_mid | (pos1 < nhigh);

  assign mclk_halves  = run ? {half1, half0} : 2'b00;
  assign period_start = run & ((pos == '0) | wrap_mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      run       <= 1'b0;
      pos       <= '0;
      act_code  <= RST_CODE;
      pend_code <= RST_CODE;
    end else begin
      start_q   <= start;
      pend_code <= pend_nxt;
      if (!run) begin
        if (start_edge) begin
          run      <= 1'b1;
          act_code <= pend_nxt;
          pos      <= '0;
        end
      end else if (wrap_mid) begin
        pos      <= PW'(1);
        act_code <= pend_nxt;
      end else if (wrap_end) begin
        pos      <= '0;
        act_code <= pend_nxt;
      end else begin
        pos <= pos2;
      end
    end
  end

  a_r2_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    pos < nhalf);

  a_r4_no_reserved_active: assert property (@(posedge clk) disable iff (!rst_n)
    act_code != '0);

  a_r5_ratio_held_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_mid && !wrap_end) |=> $stable(act_code));

  a_r6_mid_rise_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_halves == 2'b10) |-> period_start);

  a_r6_strobe_has_high: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> (mclk_halves != 2'b00));

  a_r7_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);
endmodule

// File: tb/sdclk_ratio_gen_tb.sv
`timescale 1ns/1ps
module sdclk_ratio_gen_tb;
  typedef struct {
    logic [1:0] pair;
    logic       ps;
    string      req;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] ratio_code = 3'd0;
  logic [1:0] mclk_halves;
  logic       period_start;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;
  exp_t       q[$];

  bit       m_sq = 0, m_run = 0;
  int       m_pend = 3, m_n = 6, m_h = 0;

  always #2.5 clk = ~clk;

  sdclk_ratio_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .start(start),
    .mclk_halves(mclk_halves), .period_start(period_start)
  );

  task automatic step(input logic [2:0] c, input logic s, input string r);
    exp_t e;
    bit edge_s;
    @(negedge clk);
    ratio_code = c;
    start      = s;
    @(posedge clk);
    edge_s = s && !m_sq;
    m_sq   = s;
    if (edge_s && c != 0) m_pend = c;
    if (!m_run) begin
      if (edge_s) begin
        m_run = 1;
        m_n   = m_pend + 3;
        m_h   = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        m_h++;
        if (m_h == m_n) begin
          m_h = 0;
          m_n = m_pend + 3;
        end
      end
    end
    if (!m_run) begin
      e.pair = 2'b00;
      e.ps   = 1'b0;
    end else begin
      e.pair[0] = m_h < (m_n + 1) / 2;
      e.pair[1] = (m_h + 1 == m_n) ? 1'b1 : (m_h + 1 < (m_n + 1) / 2);
      e.ps      = (m_h == 0) || (m_h + 1 == m_n);
    end
    e.req = r;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (mclk_halves !== e.pair) begin
        errors++;
        $display("FAIL %s: mclk_halves=%b expected %b", e.req, mclk_halves, e.pair);
      end
      checks++;
      if (period_start !== e.ps) begin
        errors++;
        $display("FAIL R6 (%s): period_start=%b expected %b", e.req, period_start, e.ps);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run incomplete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (mclk_halves !== 2'b00 || period_start !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs %b/%b expected 00/0", mclk_halves, period_start);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(3'(i), 1'b0, "R1");
    // R4: reserved code on the first edge starts at the reset ratio
    step(3'd0, 1'b1, "R4");
    for (int i = 0; i < 14; i++) step(3'd0, 1'b1, "R4");
    // R2: every ratio code, each started from a cleared start bit
    for (int c = 1; c < 8; c++) begin
      step(3'(c), 1'b0, "R3");
      step(3'(c), 1'b1, "R2");
      for (int i = 0; i < 20; i++) step(3'(c), 1'b1, "R2");
    end
    // R3: code changes with start held high are ignored
    for (int i = 0; i < 20; i++) step(3'(1 + (i % 6)), 1'b1, "R3");
    // R7: start low keeps the clock running
    for (int i = 0; i < 15; i++) step(3'd1, 1'b0, "R7");
    // R4: reserved code on an edge while running
    step(3'd0, 1'b1, "R4");
    for (int i = 0; i < 15; i++) step(3'd0, 1'b1, "R4");
    step(3'd0, 1'b0, "R4");
    // R5: switch from 5 to 2.5 requested partway through a period
    step(3'd2, 1'b1, "R5");
    for (int i = 0; i < 15; i++) step(3'd2, 1'b1, "R5");
    step(3'd4, 1'b0, "R5");
    step(3'd4, 1'b1, "R5");
    for (int i = 0; i < 15; i++) step(3'd4, 1'b0, "R5");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule